// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is an SPI slave, clock mode 0, that behaves like a byte-addressed serial EEPROM. It runs entirely in the system clock domain. It oversamples the serial clock, the chip-select and the data input through a synchronizer, and it drives the serial data output from a register. Five one-byte instructions are decoded:

- set the write-enable latch
- clear the write-enable latch
- read the status byte
- sequential read
- page write

A page write collects its data bytes in a one-page buffer. When the frame closes cleanly on a byte boundary, the controller starts a self-timed write cycle. During that cycle the buffered bytes are committed to the internal array, and the busy flag reads back as set for a fixed number of system clocks.

A two-bit protection level comes in on a port. It guards the top quarter, the top half or the whole array against programming, and it is reported in the status byte. While a write cycle runs, every instruction except the status read is dropped. When the cycle ends, the write-enable latch clears.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and 0x04 clears it, each taking effect when CS rises after the opcode. Opcode 0x05 streams the status byte {4'b0000, protection level[1:0], latch, busy} MSB first, refreshed at every byte boundary.
- R2: A write opcode 0x02 received while the latch is clear is ignored: no busy period, no array change, and nothing more happens until the next CS falling edge.
- R3: A write frame is the opcode, a 16-bit address MSB first (bits above the array size are ignored), then data bytes MSB first. Programming starts only when CS rises on a byte boundary after at least one data byte. A rise at any other point, or before any data byte, programs nothing and starts no busy period.
- R4: Within a write, only the low six address bits advance after each data byte. Bytes beyond 64 wrap to the start of the same 64-byte page, and the last byte sent to a location is the one kept.
- R5: The busy flag (status bit 0) is 1 for exactly WCYC system clocks after a write starts, and array updates happen only in that window.
- R6: The write-enable latch is clear once a write cycle ends.
- R7: While busy, opcodes 0x06, 0x04, 0x03 and 0x02 are ignored: the latch keeps its value and SO stays 0.
- R8: Read opcode 0x03 takes a 16-bit address, then returns bytes MSB first on SO. The address advances across the whole array and rolls from the top address to 0.
- R9: Protection level 1 guards the top quarter, level 2 the top half and level 3 the whole array. A write into a guarded address programs nothing and starts no busy period.
- R10: After reset the latch and busy flag are 0, every array byte reads 0xFF, and SO is 0 while CS is high.
- R11: An unknown opcode is ignored, and SO stays 0 for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on SCK rising edges |
| so | output | 1 | Serial data out, updated after SCK falling edges |
| prot_level | input | 2 | Protection level selecting the guarded range |

## Verification
The assertions assume the following about the inputs:

- Each SCK half-period and each CS phase lasts several system clocks, so no synchronized edge is lost.
- CS changes only while SCK is low.
- WCYC is at least the page size, so the commit sweep fits inside the busy window.
- The protection level is steady while a write frame closes.

The stimulus meets these assumptions. It drives every input on the falling system-clock edge. It holds each SCK phase for six system clocks, raises and lowers CS only with SCK low, and changes the protection level only between frames. The bench lengthens the write cycle so that status polls and ignored instructions fit inside one busy period.

// File: rtl/speep_pkg.sv
package speep_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_READ, ST_STAT, ST_WREN, ST_WRDI, ST_SKIP
  } fstate_t;

  // status byte layout: {0000, level, latch, busy}
  function automatic logic [7:0] status_byte(input logic busy, input logic wel,
                                             input logic [1:0] lvl);
    return {4'b0000, lvl, wel, busy};
  endfunction

  // guarded range: level 1 top quarter, 2 top half, 3 everything
  function automatic logic prot_hit(input logic [15:0] a, input logic [1:0] lvl,
                                    input int unsigned depth);
    int unsigned lo;
    int unsigned ai;
    ai = {16'd0, a};
    if (lvl == 2'd0) return 1'b0;
    if (lvl == 2'd3) return 1'b1;
    lo = depth - {30'd0, lvl} * (depth / 4);
    return ai >= lo;
  endfunction

  // next frame state after a complete opcode byte
  function automatic fstate_t decode_op(input logic [7:0] op, input logic busy,
                                        input logic wel);
    if (busy && op != OP_RDSR) return ST_SKIP;
    case (op)
      OP_WREN:  return ST_WREN;
      OP_WRDI:  return ST_WRDI;
      OP_RDSR:  return ST_STAT;
      OP_READ:  return ST_ADDR;
      OP_WRITE: return wel ? ST_ADDR : ST_SKIP;
      default:  return ST_SKIP;
    endcase
  endfunction

endpackage

// File: rtl/speep_sync.sv
module speep_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] st [STAGES];
  logic [W-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= INIT;
      last <= INIT;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      last <= st[STAGES-1];
    end
  end

  assign q    = st[STAGES-1];
  assign rise = q & ~last;
  assign fall = ~q & last;
endmodule

// File: rtl/speep_array.sv
module speep_array #(
  parameter int DEPTH = 1024,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/speep_wcycle.sv
module speep_wcycle #(
  parameter int WCYC = 200,
  parameter int PAGE_BYTES = 64,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          set_wel,
  input  logic          clr_wel,
  output logic          busy,
  output logic          wel,
  output logic          commit_en,
  output logic [PW-1:0] commit_idx
);
  localparam int CW = $clog2(WCYC + 1);
  localparam int TW = (CW > PW) ? CW : PW;

  logic [TW-1:0] tmr;
  logic          last_tick;

  assign last_tick = busy && (tmr == TW'(WCYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tmr  <= '0;
    end else if (busy) begin
      tmr <= tmr + 1'b1;
      if (last_tick) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wel <= 1'b0;
    else if (last_tick)       wel <= 1'b0;
    else if (set_wel && !busy) wel <= 1'b1;
    else if (clr_wel && !busy) wel <= 1'b0;
  end

  assign commit_en  = busy && ({{(32-TW){1'b0}}, tmr} < PAGE_BYTES);
  assign commit_idx = tmr[PW-1:0];
endmodule

// File: rtl/speep_frame.sv
module speep_frame
  import speep_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int PAGE_BYTES = 64,
  parameter int AW = 10,
  parameter int PW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             si_s,
  input  logic             cs_n_s,
  input  logic             cs_rise,
  input  logic             cs_fall,
  input  logic             busy,
  input  logic             wel,
  input  logic [1:0]       prot_level,
  input  logic [7:0]       rd_data,
  input  logic [PW-1:0]    buf_idx,
  output logic [AW-1:0]    rd_addr,
  output logic             so,
  output logic             set_wel,
  output logic             clr_wel,
  output logic             start_prog,
  output logic [AW-PW-1:0] page_sel,
  output logic [7:0]       buf_data,
  output logic             buf_valid
);
  fstate_t             state;
  logic [3:0]          bitcnt;
  logic [14:0]         rx;
  logic [15:0]         rx_nx;
  logic                is_rd;
  logic [AW-1:0]       addr_q;
  logic [PW-1:0]       off_q;
  logic [AW-PW-1:0]    page_q;
  logic                got_q;
  logic [7:0]          tx;
  logic [2:0]          txcnt;
  logic                so_q;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [7:0]          src;
  logic                bit_in;
  logic                bit_out;
  logic                byte_done;

  assign rx_nx     = {rx, si_s};
  assign bit_in    = sck_rise && !cs_n_s && !cs_rise && !cs_fall;
  assign bit_out   = sck_fall && !cs_n_s && !cs_rise && !cs_fall &&
                     (state == ST_READ || state == ST_STAT);
  assign byte_done = bit_in && state == ST_WDATA && bitcnt == 4'd7;
  assign src       = (state == ST_READ) ? rd_data : status_byte(busy, wel, prot_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      is_rd  <= 1'b0;
      addr_q <= '0;
      off_q  <= '0;
      page_q <= '0;
      got_q  <= 1'b0;
      tx     <= '0;
      txcnt  <= '0;
      so_q   <= 1'b0;
      pvalid <= '0;
    end else if (cs_rise) begin
      state <= ST_IDLE;
      so_q  <= 1'b0;
    end else if (cs_fall) begin
      state  <= ST_OPC;
      bitcnt <= '0;
      txcnt  <= '0;
      so_q   <= 1'b0;
    end else if (bit_in) begin
      rx <= rx_nx[14:0];
      case (state)
        ST_OPC: begin
          if (bitcnt == 4'd7) begin
            bitcnt <= '0;
            state  <= decode_op(rx_nx[7:0], busy, wel);
            is_rd  <= (rx_nx[7:0] == OP_READ);
          end else bitcnt <= bitcnt + 1'b1;
        end
        ST_ADDR: begin
          if (bitcnt == 4'd15) begin
            bitcnt <= '0;
            addr_q <= rx_nx[AW-1:0];
            off_q  <= rx_nx[PW-1:0];
            page_q <= rx_nx[AW-1:PW];
            got_q  <= 1'b0;
            if (is_rd) state <= ST_READ;
            else begin
              state  <= ST_WDATA;
              pvalid <= '0;
            end
          end else bitcnt <= bitcnt + 1'b1;
        end
        ST_WDATA: begin
          if (bitcnt == 4'd7) begin
            bitcnt        <= '0;
            pvalid[off_q] <= 1'b1;
            off_q         <= off_q + 1'b1;
            got_q         <= 1'b1;
          end else bitcnt <= bitcnt + 1'b1;
        end
        default: ;
      endcase
    end else if (bit_out) begin
      txcnt <= txcnt + 1'b1;
      if (txcnt == 3'd0) begin
        so_q <= src[7];
        tx   <= {src[6:0], 1'b0};
        if (state == ST_READ) addr_q <= addr_q + 1'b1;
      end else begin
        so_q <= tx[7];
        tx   <= {tx[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done) pbuf[off_q] <= rx_nx[7:0];
  end

  assign set_wel    = cs_rise && state == ST_WREN;
  assign clr_wel    = cs_rise && state == ST_WRDI;
  assign start_prog = cs_rise && state == ST_WDATA && bitcnt == 4'd0 && got_q &&
                      !prot_hit(16'({page_q, {PW{1'b0}}}), prot_level, MEM_BYTES);
  assign rd_addr    = addr_q;
  assign so         = so_q;
  assign page_sel   = page_q;
  assign buf_data   = pbuf[buf_idx];
  assign buf_valid  = pvalid[buf_idx];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int MEM_BYTES = 1024,
  parameter int PAGE_BYTES = 64,
  parameter int WCYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       so,
  input  logic [1:0] prot_level
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [2:0]       s_q, s_rise, s_fall;
  logic             cs_n_s, cs_rise, cs_fall, sck_rise, sck_fall, si_s;
  logic             busy, wel, set_wel, clr_wel, start_prog;
  logic             commit_en, buf_valid, mem_we;
  logic [PW-1:0]    commit_idx;
  logic [AW-PW-1:0] page_sel;
  logic [7:0]       buf_data, rd_data;
  logic [AW-1:0]    rd_addr, mem_waddr;

  speep_sync #(.W(3), .STAGES(2), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );

  assign cs_n_s   = s_q[2];
  assign cs_rise  = s_rise[2];
  assign cs_fall  = s_fall[2];
  assign sck_rise = s_rise[1];
  assign sck_fall = s_fall[1];
  assign si_s     = s_q[0];

  speep_frame #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .AW(AW), .PW(PW)) u_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
    .cs_n_s(cs_n_s), .cs_rise(cs_rise), .cs_fall(cs_fall), .busy(busy), .wel(wel),
    .prot_level(prot_level), .rd_data(rd_data), .buf_idx(commit_idx),
    .rd_addr(rd_addr), .so(so), .set_wel(set_wel), .clr_wel(clr_wel),
    .start_prog(start_prog), .page_sel(page_sel), .buf_data(buf_data),
    .buf_valid(buf_valid)
  );

  speep_wcycle #(.WCYC(WCYC), .PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_wcycle (
    .clk(clk), .rst_n(rst_n), .start(start_prog), .set_wel(set_wel),
    .clr_wel(clr_wel), .busy(busy), .wel(wel), .commit_en(commit_en),
    .commit_idx(commit_idx)
  );

  assign mem_we    = commit_en && buf_valid;
  assign mem_waddr = {page_sel, commit_idx};

  speep_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(buf_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/speep_checker.sv
module speep_checker
  import speep_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int AW = 10,
  parameter int WCYC = 200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wel,
  input logic          cs_rise,
  input logic          cs_n_s,
  input logic          so,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [1:0]    prot_level
);
  int unsigned bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == WCYC)); // R5
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R6
  AST_LATCH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel); // R7
  AST_START_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise)); // R3
  AST_GUARD_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !prot_hit(16'(mem_waddr), prot_level, MEM_BYTES)); // R9
  AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !so); // R10
endmodule

bind spi_eeprom_slave speep_checker #(.MEM_BYTES(MEM_BYTES), .AW(AW), .WCYC(WCYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .cs_rise(cs_rise),
  .cs_n_s(cs_n_s), .so(so), .mem_we(mem_we), .mem_waddr(mem_waddr),
  .prot_level(prot_level)
);

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
  localparam int DEPTH = 1024;
  localparam int WC = 2000;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so;
  logic [1:0] prot_level = 2'd0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  spi_eeprom_slave #(.MEM_BYTES(DEPTH), .PAGE_BYTES(64), .WCYC(WC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
    .prot_level(prot_level)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic desel();
    tick(H);
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  task automatic bits(input logic [7:0] d, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      si = d[i];
      tick(H);
      r[i] = so;
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    bits(d, 8, r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel();
    xfer(op, r);
    desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    sel();
    xfer(8'h05, r);
    xfer(8'h00, st);
    desel();
  endtask

  function automatic logic [7:0] pat(input logic [7:0] b, input int k);
    return b + 8'(k * 7);
  endfunction

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] b);
    logic [7:0] r;
    sel();
    xfer(8'h02, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(pat(b, k), r);
    desel();
  endtask

  task automatic model_write(input logic [15:0] a, input int n, input logic [7:0] b);
    int base;
    base = int'(a) % DEPTH;
    base = base - (base % 64);
    for (int k = 0; k < n; k++) model[base + ((int'(a) + k) % 64)] = pat(b, k);
  endtask

  task automatic read_chk(input string tag, input logic [15:0] a, input int n);
    logic [7:0] r;
    sel();
    xfer(8'h03, r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      check(tag, r, model[(int'(a) + k) % DEPTH]);
    end
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [7:0] r;
    logic [15:0] a;
    bit guarded;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R10 reset state
    check("R10 so idle", so, 0);
    rdsr(st);
    check("R10 status after reset", st, 8'h00);
    read_chk("R10 erased array", 16'h0000, 4);

    // R2 write without latch
    do_write(16'h0010, 1, 8'h55);
    rdsr(st);
    check("R2 no busy", st, 8'h00);
    read_chk("R2 array unchanged", 16'h0010, 1);

    // R1 latch set and clear
    cmd1(8'h06);
    rdsr(st);
    check("R1 latch set", st, 8'h02);
    cmd1(8'h04);
    rdsr(st);
    check("R1 latch cleared", st, 8'h00);

    // R3 R5 R7 normal write with ignored commands during busy
    cmd1(8'h06);
    do_write(16'h0105, 4, 8'h11);
    model_write(16'h0105, 4, 8'h11);
    rdsr(st);
    check("R5 busy set", st, 8'h03);
    cmd1(8'h04);
    sel();
    xfer(8'h03, r);
    xfer(8'h01, r);
    xfer(8'h05, r);
    xfer(8'h00, r);
    check("R7 read ignored while busy", r, 8'h00);
    desel();
    rdsr(st);
    check("R7 latch kept while busy", st, 8'h03);
    tick(WC + 100);
    rdsr(st);
    check("R6 latch clear after cycle", st, 8'h00);
    read_chk("R3 data programmed", 16'h0105, 4);

    // R3 abort mid-byte
    cmd1(8'h06);
    sel();
    xfer(8'h02, r);
    xfer(8'h00, r);
    xfer(8'h20, r);
    xfer(8'hAA, r);
    bits(8'h55, 3, r);
    desel();
    rdsr(st);
    check("R3 abort no busy", st, 8'h02);
    read_chk("R3 abort array unchanged", 16'h0020, 2);

    // R3 no data byte
    sel();
    xfer(8'h02, r);
    xfer(8'h00, r);
    xfer(8'h30, r);
    desel();
    rdsr(st);
    check("R3 empty write no busy", st, 8'h02);
    cmd1(8'h04);

    // R4 page wrap: 70 bytes starting at offset 60 of page 0x80
    cmd1(8'h06);
    do_write(16'h00BC, 70, 8'h40);
    model_write(16'h00BC, 70, 8'h40);
    tick(WC + 100);
    read_chk("R4 page wrap", 16'h0080, 64);
    read_chk("R4 next page untouched", 16'h00C0, 2);

    // R8 rollover, R3 upper address bits ignored
    cmd1(8'h06);
    do_write(16'h03FE, 2, 8'h90);
    model_write(16'h03FE, 2, 8'h90);
    tick(WC + 100);
    read_chk("R8 read rollover", 16'h03FE, 4);
    read_chk("R3 upper bits ignored", 16'h8105, 2);

    // R11 unknown opcode
    sel();
    xfer(8'hAB, r);
    xfer(8'h00, r);
    check("R11 so quiet", r, 8'h00);
    desel();
    rdsr(st);
    check("R11 status unchanged", st, 8'h00);

    // R9 protection sweep over every level and quarter
    for (int lvl = 0; lvl < 4; lvl++) begin
      prot_level = 2'(lvl);
      tick(2);
      rdsr(st);
      check("R1 level in status", st, lvl << 2);
      for (int q = 0; q < 4; q++) begin
        a = 16'(q * 256 + lvl * 16 + 3);
        guarded = (lvl == 3) || (lvl != 0 && int'(a) >= DEPTH - lvl * 256);
        cmd1(8'h06);
        do_write(a, 1, 8'(8'hC0 + lvl * 4 + q));
        rdsr(st);
        check("R9 busy follows guard", st, (lvl << 2) | (guarded ? 2 : 3));
        if (guarded) cmd1(8'h04);
        else begin
          model_write(a, 1, 8'(8'hC0 + lvl * 4 + q));
          tick(WC + 100);
        end
        read_chk("R9 guarded write", a, 1);
      end
    end
    prot_level = 2'd0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule